// File: doc/BRIEF.md
# Three-Wire SPI Temperature Read Sequencer

This block runs one complete temperature read on a sensor attached through a three-wire SPI link, where a single bidirectional data pin carries both the command and the reply. A one-cycle start pulse opens a frame: chip select goes low, a 16-bit read command leaves the block most significant bit first, and the data pin is then released while chip select stays low for a settling interval. After that interval the block clocks in a 16-bit reply, raises chip select again and presents the signed temperature field with a one-cycle valid strobe.

The serial clock is derived from the system clock by a divider computed at build time from the system clock rate and the highest serial rate allowed, so the link never runs faster than that limit (2 MHz by default). The settling interval is also computed from the system clock rate, 1000 us by default. Clock polarity and clock phase are build-time parameters. The data pin is brought out as separate output, output-enable and input signals so that a pad cell at the chip edge resolves it. A higher-level timer decides how often to pulse start.

Top module: `thermo_spi_reader`

## Requirements
- R1: After reset, chip select is high, busy and valid are low, the data output enable is low, the serial clock rests at its idle level CPOL, and the temperature output is zero.
- R2: A start pulse while idle makes chip select low and busy high on the next cycle; a start pulse while a frame is in progress has no effect: the frame finishes with exactly one valid strobe and no second frame follows.
- R3: The command phase sends the word CMD_WORD (default 0x8000) as 16 bits, most significant first, with the data output enable high for the whole phase.
- R4: The serial clock half-period is HALF_CYC = ceil(CLK_HZ / (2 * SCLK_MAX_HZ)) system cycles, each phase has exactly 16 serial clock periods (64 edges per frame), and the clock sits at CPOL whenever chip select is high.
- R5: With CPHA = 0 both sides sample on the edge that leaves the idle level and change data on the edge that returns to it; with CPHA = 1 they change data on the edge leaving idle and sample on the return edge.
- R6: Between the phases chip select stays low, the data output enable drops one system cycle after the last command edge, and the time from the last command edge to the first reply edge is SETTLE_CYC + HALF_CYC system cycles, with SETTLE_CYC = (CLK_HZ / 1e6) * SETTLE_US.
- R7: The reply phase shifts in 16 bits from the data input, most significant first, with the data output enable low throughout.
- R8: Chip select rises one half-period after the last reply edge, in the same cycle as the valid strobe, and busy falls in that same cycle.
- R9: The temperature output is reply bits 15:3 taken as a 13-bit two's-complement number (arithmetic shift right by 3, 0.0625 degC per LSB); reply bits 2:0 have no effect on it.
- R10: The valid strobe lasts exactly one system cycle, and the temperature output holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one read frame (pulse) |
| busy_o | output | 1 | High from an accepted start until the valid strobe |
| temp_o | output | 13 | Signed temperature, 0.0625 degC per LSB |
| temp_valid_o | output | 1 | One-cycle strobe marking a new temperature |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| sdio_out_o | output | 1 | Data value driven onto the shared pin |
| sdio_oe_o | output | 1 | Output enable for the shared pin |
| sdio_in_i | input | 1 | Data value read from the shared pin |

## Verification
Two instances, one in phase/polarity mode 0 and one in mode 3, each talk to a behavioural sensor that captures the command on its own sampling edges and drives the reply only after the pin is released. Replies cover the two signed extremes, zero with nonzero discarded bits, minus one and an alternating pattern; a design that shifted logically, kept the wrong bit slice or sampled on the wrong edge would report a mismatched temperature. The link timing is measured edge to edge, so a divider off by one, a settle count off by one, a missing or extra clock edge, or a pin still driven when the sensor starts to answer shows up as a timing or contention failure. A second start pulse in the middle of a frame checks that the busy guard neither restarts nor repeats the transaction.

// File: rtl/thermo_spi_pkg.sv
`timescale 1ns/1ps
package thermo_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_SETTLE,
        ST_READ,
        ST_HOLD
    } seq_state_e;

    function automatic int div_ceil(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/thermo_spi_clkdiv.sv
`timescale 1ns/1ps
module thermo_spi_clkdiv #(
    parameter int HALF_CYC = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

    logic [HC_W-1:0] hc_d, hc_q;

    always_comb begin
        hc_d   = hc_q;
        tick_o = 1'b0;
        if (!run_i) begin
            hc_d = '0;
        end else if (hc_q == HC_LAST) begin
            tick_o = 1'b1;
            hc_d   = '0;
        end else begin
            hc_d = hc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hc_q <= '0;
        else        hc_q <= hc_d;
    end
endmodule

// File: rtl/thermo_spi_settle.sv
`timescale 1ns/1ps
module thermo_spi_settle #(
    parameter int SETTLE_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CYC  = (SETTLE_CYC > 0) ? SETTLE_CYC : 1;
    localparam int CW   = $clog2(CYC + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          act_d, act_q;

    always_comb begin
        cnt_d  = cnt_q;
        act_d  = act_q;
        done_o = 1'b0;
        if (load_i) begin
            cnt_d = CNT_INIT;
            act_d = 1'b1;
        end else if (act_q) begin
            if (cnt_q == '0) begin
                done_o = 1'b1;
                act_d  = 1'b0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            act_q <= act_d;
        end
    end
endmodule

// File: rtl/thermo_spi_shifter.sv
`timescale 1ns/1ps
module thermo_spi_shifter #(
    parameter int                    FRAME_BITS = 16,
    parameter int                    FIELD_LSB  = 3,
    parameter logic [FRAME_BITS-1:0] CMD_WORD   = 16'h8000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic                            shift_tx_i,
    input  logic                            sample_i,
    input  logic                            rx_bit_i,
    output logic                            tx_bit_o,
    output logic [FRAME_BITS-FIELD_LSB-1:0] field_o
);
    logic [FRAME_BITS-1:0] tx_d, tx_q;
    logic [FRAME_BITS-1:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load_i) begin
            tx_d = CMD_WORD;
        end else if (shift_tx_i) begin
            tx_d = {tx_q[FRAME_BITS-2:0], 1'b0};
        end
        if (sample_i) begin
            rx_d = {rx_q[FRAME_BITS-2:0], rx_bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_bit_o = tx_q[FRAME_BITS-1];
    assign field_o  = rx_q[FRAME_BITS-1:FIELD_LSB];
endmodule

// File: rtl/thermo_spi_reader.sv
`timescale 1ns/1ps
module thermo_spi_reader
    import thermo_spi_pkg::*;
#(
    parameter int                    CLK_HZ      = 100_000_000,
    parameter int                    SCLK_MAX_HZ = 2_000_000,
    parameter int                    SETTLE_US   = 1000,
    parameter bit                    CPOL        = 1'b0,
    parameter bit                    CPHA        = 1'b0,
    parameter int                    FRAME_BITS  = 16,
    parameter int                    TEMP_SHIFT  = 3,
    parameter logic [FRAME_BITS-1:0] CMD_WORD    = 16'h8000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_i,
    output logic                                   busy_o,
    output logic signed [FRAME_BITS-TEMP_SHIFT-1:0] temp_o,
    output logic                                   temp_valid_o,
    output logic                                   cs_n_o,
    output logic                                   sclk_o,
    output logic                                   sdio_out_o,
    output logic                                   sdio_oe_o,
    input  logic                                   sdio_in_i
);
    localparam int HALF_CYC_RAW = div_ceil(CLK_HZ, 2 * SCLK_MAX_HZ);
    localparam int HALF_CYC     = (HALF_CYC_RAW > 0) ? HALF_CYC_RAW : 1;
    localparam int SETTLE_CYC   = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int TEMP_W       = FRAME_BITS - TEMP_SHIFT;
    localparam int EDGES        = 2 * FRAME_BITS;
    localparam int EDGE_W       = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);

    typedef struct packed {
        seq_state_e          state;
        logic                sclk;
        logic                cs_n;
        logic                oe;
        logic                busy;
        logic                valid;
        logic [EDGE_W-1:0]   edge_cnt;
        logic [TEMP_W-1:0]   temp;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:    ST_IDLE,
        sclk:     CPOL,
        cs_n:     1'b1,
        oe:       1'b0,
        busy:     1'b0,
        valid:    1'b0,
        edge_cnt: '0,
        temp:     '0
    };

    seq_regs_t s_d, s_q;

    logic              tick;
    logic              run;
    logic              settle_load;
    logic              settle_done;
    logic              load_cmd;
    logic              shift_tx;
    logic              sample_rx;
    logic              tx_bit;
    logic [TEMP_W-1:0] rx_field;
    logic              lead_edge;
    logic              tx_on_edge;
    logic              rx_on_edge;
    logic              last_edge;

    assign run       = (s_q.state == ST_CMD) || (s_q.state == ST_READ) ||
                       (s_q.state == ST_HOLD);
    assign lead_edge = ~s_q.edge_cnt[0];
    assign last_edge = (s_q.edge_cnt == EDGE_LAST);

    // Edge policy chosen by the clock phase parameter.
    generate
        if (CPHA == 1'b0) begin : g_phase_lead_sample
            assign rx_on_edge = lead_edge;
            assign tx_on_edge = ~lead_edge;
        end else begin : g_phase_trail_sample
            assign rx_on_edge = ~lead_edge;
            assign tx_on_edge = lead_edge & (s_q.edge_cnt != '0);
        end
    endgenerate

    thermo_spi_clkdiv #(
        .HALF_CYC (HALF_CYC)
    ) clkdiv_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    thermo_spi_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) settle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (settle_load),
        .done_o (settle_done)
    );

    thermo_spi_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .FIELD_LSB  (TEMP_SHIFT),
        .CMD_WORD   (CMD_WORD)
    ) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_cmd),
        .shift_tx_i (shift_tx),
        .sample_i   (sample_rx),
        .rx_bit_i   (sdio_in_i),
        .tx_bit_o   (tx_bit),
        .field_o    (rx_field)
    );

    always_comb begin
        s_d         = s_q;
        s_d.valid   = 1'b0;
        load_cmd    = 1'b0;
        shift_tx    = 1'b0;
        sample_rx   = 1'b0;
        settle_load = 1'b0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state    = ST_CMD;
                    s_d.cs_n     = 1'b0;
                    s_d.busy     = 1'b1;
                    s_d.oe       = 1'b1;
                    s_d.sclk     = CPOL;
                    s_d.edge_cnt = '0;
                    load_cmd     = 1'b1;
                end
            end
            ST_CMD: begin
                if (tick) begin
                    s_d.sclk = ~s_q.sclk;
                    shift_tx = tx_on_edge;
                    if (last_edge) begin
                        s_d.state    = ST_SETTLE;
                        s_d.edge_cnt = '0;
                        settle_load  = 1'b1;
                    end else begin
                        s_d.edge_cnt = s_q.edge_cnt + 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                s_d.oe = 1'b0;
                if (settle_done) begin
                    s_d.state = ST_READ;
                end
            end
            ST_READ: begin
                if (tick) begin
                    s_d.sclk  = ~s_q.sclk;
                    sample_rx = rx_on_edge;
                    if (last_edge) begin
                        s_d.state    = ST_HOLD;
                        s_d.edge_cnt = '0;
                    end else begin
                        s_d.edge_cnt = s_q.edge_cnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    s_d.state = ST_IDLE;
                    s_d.cs_n  = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.valid = 1'b1;
                    s_d.temp  = rx_field;
                end
            end
            default: begin
                s_d = SEQ_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RESET;
        else        s_q <= s_d;
    end

    assign busy_o       = s_q.busy;
    assign temp_o       = s_q.temp;
    assign temp_valid_o = s_q.valid;
    assign cs_n_o       = s_q.cs_n;
    assign sclk_o       = s_q.sclk;
    assign sdio_oe_o    = s_q.oe;
    assign sdio_out_o   = s_q.oe & tx_bit;
endmodule

// File: rtl/thermo_spi_reader_chk.sv
`timescale 1ns/1ps
module thermo_spi_reader_chk #(
    parameter bit CPOL   = 1'b0,
    parameter int TEMP_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic [TEMP_W-1:0] temp_o,
    input logic              temp_valid_o,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              sdio_oe_o
);
    assert_select_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_clock_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (sclk_o == CPOL));

    assert_drive_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe_o |-> (!cs_n_o && busy_o));

    assert_release_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdio_oe_o) |-> !cs_n_o);

    assert_deselect_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (temp_valid_o && !busy_o));

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> temp_valid_o);

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        temp_valid_o |=> !temp_valid_o);

    assert_temp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid_o |-> $stable(temp_o));
endmodule

bind thermo_spi_reader thermo_spi_reader_chk #(
    .CPOL   (CPOL),
    .TEMP_W (FRAME_BITS - TEMP_SHIFT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .temp_o       (temp_o),
    .temp_valid_o (temp_valid_o),
    .cs_n_o       (cs_n_o),
    .sclk_o       (sclk_o),
    .sdio_oe_o    (sdio_oe_o)
);

// File: tb/thermo_spi_reader_tb_top.sv
`timescale 1ns/1ps
module thermo_sensor_model #(
    parameter bit CPOL = 1'b0,
    parameter bit CPHA = 1'b0
) (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        line,
    input  logic        oe,
    input  logic [15:0] resp,
    output logic        drv_en,
    output logic        drv_bit,
    output logic [15:0] cmd,
    output int          edges,
    output longint      t_e0,
    output longint      t_e1,
    output longint      t_cmd_end,
    output longint      t_rd_start,
    output int          oe_err
);
    int ptr;
    int k;
    bit lead;

    initial begin
        drv_en = 0; drv_bit = 0; cmd = 0; edges = 0; oe_err = 0; ptr = 15;
        t_e0 = 0; t_e1 = 0; t_cmd_end = 0; t_rd_start = 0;
    end

    always @(negedge cs_n) begin
        edges = 0; cmd = 0; drv_en = 0; oe_err = 0; ptr = 15;
    end

    always @(posedge cs_n) drv_en = 0;

    // Mode 0 sensor presents its first reply bit once the pin is released.
    always @(negedge oe) begin
        if (cs_n === 1'b0 && edges == 32 && CPHA == 1'b0) begin
            drv_en  = 1;
            drv_bit = resp[15];
            ptr     = 14;
        end
    end

    always @(sclk) begin
        if (cs_n === 1'b0) begin
            k    = edges;
            lead = (sclk != CPOL);
            if (k == 0)  t_e0 = $time;
            if (k == 1)  t_e1 = $time;
            if (k == 31) t_cmd_end = $time;
            if (k == 32) t_rd_start = $time;
            if (k < 32 && (CPHA ? !lead : lead)) begin
                cmd = {cmd[14:0], line};
                if (!oe) oe_err = oe_err + 1;
            end
            if (CPHA == 1'b0) begin
                if (k > 32 && !lead && ptr >= 0) begin
                    drv_bit = resp[ptr];
                    ptr     = ptr - 1;
                end
            end else begin
                if (k >= 32 && lead) begin
                    drv_en  = 1;
                    drv_bit = resp[15 - (k - 32) / 2];
                end
            end
            edges = k + 1;
        end
    end
endmodule

module thermo_spi_reader_tb_top;
    localparam int CLK_HZ   = 250_000_000;
    localparam int SCLK_HZ  = 12_500_000;
    localparam int SET_US   = 2;
    localparam int HALF     = (CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
    localparam int SET_CYC  = (CLK_HZ / 1_000_000) * SET_US;
    localparam int PERIOD   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] resp = 16'h0;

    always #(PERIOD / 2) clk = ~clk;

    logic busy0, val0, cs0, sclk0, out0, oe0, in0, en0, bit0;
    logic busy1, val1, cs1, sclk1, out1, oe1, in1, en1, bit1;
    logic signed [12:0] temp0, temp1;
    logic [15:0] cmd0, cmd1;
    int edges0, edges1, oeerr0, oeerr1;
    longint e0a, e1a, ce0, rs0, e0b, e1b, ce1, rs1;

    assign in0 = oe0 ? out0 : (en0 ? bit0 : 1'b1);
    assign in1 = oe1 ? out1 : (en1 ? bit1 : 1'b1);

    thermo_spi_reader #(.CLK_HZ(CLK_HZ), .SCLK_MAX_HZ(SCLK_HZ), .SETTLE_US(SET_US),
                        .CPOL(1'b0), .CPHA(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy0), .temp_o(temp0),
        .temp_valid_o(val0), .cs_n_o(cs0), .sclk_o(sclk0), .sdio_out_o(out0),
        .sdio_oe_o(oe0), .sdio_in_i(in0));

    thermo_spi_reader #(.CLK_HZ(CLK_HZ), .SCLK_MAX_HZ(SCLK_HZ), .SETTLE_US(SET_US),
                        .CPOL(1'b1), .CPHA(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy1), .temp_o(temp1),
        .temp_valid_o(val1), .cs_n_o(cs1), .sclk_o(sclk1), .sdio_out_o(out1),
        .sdio_oe_o(oe1), .sdio_in_i(in1));

    thermo_sensor_model #(.CPOL(1'b0), .CPHA(1'b0)) sens0_i (
        .cs_n(cs0), .sclk(sclk0), .line(in0), .oe(oe0), .resp(resp), .drv_en(en0),
        .drv_bit(bit0), .cmd(cmd0), .edges(edges0), .t_e0(e0a), .t_e1(e1a),
        .t_cmd_end(ce0), .t_rd_start(rs0), .oe_err(oeerr0));

    thermo_sensor_model #(.CPOL(1'b1), .CPHA(1'b1)) sens1_i (
        .cs_n(cs1), .sclk(sclk1), .line(in1), .oe(oe1), .resp(resp), .drv_en(en1),
        .drv_bit(bit1), .cmd(cmd1), .edges(edges1), .t_e0(e0b), .t_e1(e1b),
        .t_cmd_end(ce1), .t_rd_start(rs1), .oe_err(oeerr1));

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int strobes0 = 0, strobes1 = 0;
    int contention = 0;
    bit pv0 = 0, pv1 = 0;
    logic signed [12:0] q0[$];
    logic signed [12:0] q1[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Scoreboard monitors: pop an expected temperature on every strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (oe0 && en0) contention++;
            if (oe1 && en1) contention++;
            if (val0) begin
                strobes0++;
                check(!pv0, "R10", "mode0 strobe wider than one cycle", 1, 0);
                check(cs0 && !busy0, "R8", "mode0 cs/busy at strobe", {cs0, busy0}, 2);
                if (q0.size() == 0) check(0, "R2", "mode0 unexpected strobe", 1, 0);
                else begin
                    logic signed [12:0] e;
                    e = q0.pop_front();
                    check(temp0 == e, "R9", "mode0 temperature", temp0, e);
                end
            end
            if (val1) begin
                strobes1++;
                check(!pv1, "R10", "mode3 strobe wider than one cycle", 1, 0);
                check(cs1 && !busy1, "R8", "mode3 cs/busy at strobe", {cs1, busy1}, 2);
                if (q1.size() == 0) check(0, "R2", "mode3 unexpected strobe", 1, 0);
                else begin
                    logic signed [12:0] e;
                    e = q1.pop_front();
                    check(temp1 == e, "R9", "mode3 temperature", temp1, e);
                end
            end
            pv0 = val0;
            pv1 = val1;
        end
    end

    task automatic run_read(input logic [15:0] word, input bit second_start);
        int s0, s1, waited;
        resp = word;
        q0.push_back($signed(word[15:3]));
        q1.push_back($signed(word[15:3]));
        s0 = strobes0;
        s1 = strobes1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy0 && !cs0, "R2", "mode0 busy/cs after start", {busy0, cs0}, 2);
        check(busy1 && !cs1, "R2", "mode3 busy/cs after start", {busy1, cs1}, 2);
        if (second_start) begin
            repeat (200) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        waited = 0;
        while ((strobes0 == s0 || strobes1 == s1) && waited < 6000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 6000, "R8", "watchdog waiting for strobe", waited, 6000);
        if (waited >= 6000) finish_run();
        check(cmd0 == 16'h8000, "R3", "mode0 command word", cmd0, 16'h8000);
        check(cmd1 == 16'h8000, "R3", "mode3 command word", cmd1, 16'h8000);
        check(oeerr0 == 0 && oeerr1 == 0, "R3", "pin released during command",
              oeerr0 + oeerr1, 0);
        check(edges0 == 64, "R4", "mode0 edges per frame", edges0, 64);
        check(edges1 == 64, "R5", "mode3 edges per frame", edges1, 64);
        check((e1a - e0a) == HALF * PERIOD, "R4", "mode0 half period ns", e1a - e0a,
              HALF * PERIOD);
        check((rs0 - ce0) == (SET_CYC + HALF) * PERIOD, "R6", "mode0 settle gap ns",
              rs0 - ce0, (SET_CYC + HALF) * PERIOD);
        check((rs1 - ce1) == (SET_CYC + HALF) * PERIOD, "R6", "mode3 settle gap ns",
              rs1 - ce1, (SET_CYC + HALF) * PERIOD);
        check(contention == 0, "R7", "pin driven by both sides", contention, 0);
        if (second_start) begin
            repeat (1500) @(negedge clk);
            check(strobes0 == s0 + 1 && strobes1 == s1 + 1, "R2",
                  "strobes after ignored start", strobes0 - s0, 1);
            check(!busy0 && cs0 && !busy1 && cs1, "R2", "idle after ignored start",
                  {busy0, cs0, busy1, cs1}, 5);
        end
        repeat (40) @(negedge clk);
        check(temp0 == $signed(word[15:3]), "R10", "mode0 temperature held", temp0,
              $signed(word[15:3]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R8", "global watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(cs0 && cs1 && !busy0 && !busy1 && !val0 && !val1 && !oe0 && !oe1,
              "R1", "reset control outputs", {cs0, busy0, val0, oe0}, 8);
        check(sclk0 == 1'b0 && sclk1 == 1'b1, "R1", "reset clock idle levels",
              {sclk0, sclk1}, 1);
        check(temp0 == 0 && temp1 == 0, "R1", "reset temperature", temp0, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        run_read(16'h0C80, 0);  // +25.0 C: R9
        run_read(16'hE480, 0);  // -55.0 C: R9 sign extension
        run_read(16'h7FF8, 0);  // largest positive field
        run_read(16'h8000, 0);  // most negative field
        run_read(16'h0007, 0);  // discarded low bits only -> 0
        run_read(16'hFFFF, 0);  // -1
        run_read(16'hA5A5, 1);  // second start mid-frame ignored: R2
        run_read(16'h5A5A, 0);
        check(q0.size() == 0 && q1.size() == 0, "R10", "scoreboard drained",
              q0.size() + q1.size(), 0);
        finish_run();
    end
endmodule